// File: doc/BRIEF.md
# PCIe Root Port Legacy Interrupt Queue

This block keeps the legacy interrupt state of a PCIe root port. Each time one of the four INTx lanes changes level, the upstream logic pulses `ev_valid` with the lane number and the new level. The block stores that event in a small circular queue. Software drains the queue through a 32-bit register port. Reading a queue register shows the oldest event and leaves it in place. Writing either queue register discards that event.

A pending register records that an INTx event has arrived. A mask register selects which pending bits drive the single level interrupt `irq_o`. A control/status register holds the bridge-enable bit, a live "queue holds entries" flag and a sticky overflow flag. A read-only PHY status register reports the link-up input. Register reads are combinational from `reg_addr`. Writes take effect at the rising clock edge on which `reg_wr` is high.

Top module: `rp_intx_queue`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty and the overflow flag, bridge enable, pending register, mask register and `irq_o` are all zero. Register 0x148 reads 0 and register 0x158 reads 0.
- R2: A queued event is presented at offset 0x158 as follows: bit 31 = 1 (valid), bit 29 = level (1 assert, 0 deassert), bits 28:27 = lane, and all other bits 0. Offset 0x15C reads 0 for every INTx event.
- R3: The ring has 16 slots and holds at most 15 events. An event arriving while 15 are stored is dropped and sets the sticky overflow flag, bit 19 of 0x148. Writing 1 to bit 19 of 0x148 clears the flag.
- R4: Reading 0x158 or 0x15C returns 0 while the queue is empty. Reading either register does not remove an entry.
- R5: A write of any value to 0x158 or 0x15C removes the oldest entry, and entries leave in arrival order. A write to either register while the queue is empty has no effect.
- R6: Bit 16 of the pending register 0x138 is set by every stored event. Writing 1 to a bit of 0x138 clears that bit. After such a write, bit 16 is set again if the queue still holds entries. Bit 17 (MSI) reads 0.
- R7: Offset 0x13C is a 32-bit read/write mask. `irq_o` is high exactly when some bit is set in both the pending register and the mask.
- R8: Offset 0x144 reads `link_up` at bit 11 and 0 in every other bit.
- R9: Bit 0 of 0x148 is a read/write bridge enable, driven out on `bridge_en_o`. Bit 18 of 0x148 reads 1 exactly when the queue holds entries.
- R10: Any other offset reads 0, and writes to it change no state.
- R11: An event and a removal in the same cycle both take effect. The full test uses the occupancy before that cycle, so an event that arrives while the queue is full is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | One-cycle strobe for an INTx lane event |
| ev_lane | input | 2 | Lane number of the event |
| ev_level | input | 1 | New lane level: 1 assert, 0 deassert |
| link_up | input | 1 | Link status reported in 0x144 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt: (pending AND mask) nonzero |
| bridge_en_o | output | 1 | Bridge enable bit |

## Verification
The bench fills the ring to its 15-entry limit and pushes once more. A design that used all 16 slots, or that let the extra event through, would show a wrong entry on drain or a missing overflow flag. It writes the queue register while the queue is empty and then checks that the next event is still read back correctly. A read pointer that moved on that write would run ahead of the write pointer and report stale data.

It clears the pending bit while entries remain and expects the bit to reappear; a design without that re-assertion would drop the interrupt. It also issues an event and a removal in the same cycle, both on a one-entry queue and on a full queue. This exposes a design that lets the removal free a slot for the simultaneous event, or that loses one of the two operations.

// File: rtl/rpiq_pkg.sv
// Package: shared offsets, bit positions and the queue entry type
// for the root-port legacy interrupt queue.
// Assumes 32-bit registers and four INTx lanes.
package rpiq_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANE_W = 2;

    // Register byte offsets (software-visible, kept fixed)
    localparam int unsigned OFF_PEND  = 'h138;
    localparam int unsigned OFF_MASK  = 'h13C;
    localparam int unsigned OFF_PHY   = 'h144;
    localparam int unsigned OFF_CTL   = 'h148;
    localparam int unsigned OFF_EVW0  = 'h158;
    localparam int unsigned OFF_EVW1  = 'h15C;

    // Bit positions
    localparam int unsigned B_INTX    = 16;
    localparam int unsigned B_LINK    = 11;
    localparam int unsigned B_BRIDGE  = 0;
    localparam int unsigned B_NEMPTY  = 18;
    localparam int unsigned B_OVF     = 19;
    localparam int unsigned B_LANE_LO = 27;
    localparam int unsigned B_LEVEL   = 29;
    localparam int unsigned B_VALID   = 31;

    typedef struct packed {
        logic              level;
        logic [LANE_W-1:0] lane;
    } intx_ev_t;

    // Format a stored event as the first queue word
    function automatic logic [DATA_W-1:0] ev_word(intx_ev_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_VALID] = 1'b1;
        w[B_LEVEL] = e.level;
        w[B_LANE_LO +: LANE_W] = e.lane;
        return w;
    endfunction
endpackage

// File: rtl/rpiq_fifo.sv
// Circular event store with 2**PTR_W slots. One slot always stays
// unused, so full means (write pointer + 1) == read pointer.
// Assumes pop is only acted on when not empty; push checks the
// occupancy before this cycle (a same-cycle pop frees nothing).
module rpiq_fifo
    import rpiq_pkg::*;
#(
    parameter int unsigned PTR_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  intx_ev_t push_ev,
    input  logic     pop,
    output logic     push_ok,
    output logic     dropped,
    output logic     nonempty,
    output intx_ev_t head,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam int unsigned DEPTH = 1 << PTR_W;

    intx_ev_t   slot [DEPTH];
    logic       full;
    logic       pop_ok;

    // Occupancy decode from the two pointers
    always_comb begin
        full     = (wr_ptr + PTR_W'(1)) == rd_ptr;
        nonempty = wr_ptr != rd_ptr;
        push_ok  = push && !full;
        dropped  = push && full;
        pop_ok   = pop && nonempty;
        head     = slot[rd_ptr];
    end

    // Per-slot storage: write the slot the write pointer names
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(s))
                slot[s] <= push_ev;
        end
    end

    // Pointer advance on accepted push and effective pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end
endmodule

// File: rtl/rpiq_pend.sv
// Pending and mask registers with the level interrupt output.
// The INTx pending bit is set by every stored event. A clearing
// write re-asserts it while the queue still holds entries.
// No MSI source exists here, so the MSI pending bit stays zero.
module rpiq_pend
    import rpiq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok,
    input  logic              nonempty,
    input  logic              pend_wr,
    input  logic              pend_clr_intx,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    output logic              pend_intx,
    output logic [DATA_W-1:0] pend_word,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);
    // Pending INTx bit: set on store, write-1-clear, re-forced when non-empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_intx <= 1'b0;
        else if (push_ok)
            pend_intx <= 1'b1;
        else if (pend_wr)
            pend_intx <= (pend_intx && !pend_clr_intx) || nonempty;
    end

    // Mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    // Pending word and interrupt level
    always_comb begin
        pend_word         = '0;
        pend_word[B_INTX] = pend_intx;
        irq               = |(pend_word & mask_q);
    end
endmodule

// File: rtl/rpiq_ctl.sv
// Root-port control/status state: bridge enable and the sticky
// overflow flag. A drop in the same cycle as a clear wins.
module rpiq_ctl
    import rpiq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_bridge,
    input  logic wr_ovf_clr,
    input  logic dropped,
    output logic bridge_en,
    output logic ovf
);
    // Bridge enable follows bit 0 of each control write
    always_ff @(posedge clk) begin
        if (!rst_n)      bridge_en <= 1'b0;
        else if (ctl_wr) bridge_en <= wr_bridge;
    end

    // Sticky overflow: set on drop, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf <= 1'b0;
        else if (dropped)              ovf <= 1'b1;
        else if (ctl_wr && wr_ovf_clr) ovf <= 1'b0;
    end
endmodule

// File: rtl/rp_intx_queue.sv
// Top: root-port legacy interrupt queue with a 32-bit register port.
// Reads are combinational and have no side effects. Writes act on
// the clock edge with reg_wr high. Unmapped offsets read zero.
module rp_intx_queue
    import rpiq_pkg::*;
#(
    parameter int unsigned PTR_W  = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [LANE_W-1:0] ev_lane,
    input  logic              ev_level,
    input  logic              link_up,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              bridge_en_o
);
    logic             sel_pend, sel_mask, sel_phy, sel_ctl, sel_ev0, sel_ev1;
    logic             push_ok, dropped, nonempty, pend_intx, ovf_flag;
    intx_ev_t         in_ev, head_ev;
    logic [PTR_W-1:0] fifo_wp, fifo_rp;
    logic [DATA_W-1:0] pend_word, mask_q;

    // Offset decode
    always_comb begin
        sel_pend = reg_addr == ADDR_W'(OFF_PEND);
        sel_mask = reg_addr == ADDR_W'(OFF_MASK);
        sel_phy  = reg_addr == ADDR_W'(OFF_PHY);
        sel_ctl  = reg_addr == ADDR_W'(OFF_CTL);
        sel_ev0  = reg_addr == ADDR_W'(OFF_EVW0);
        sel_ev1  = reg_addr == ADDR_W'(OFF_EVW1);
        in_ev.lane  = ev_lane;
        in_ev.level = ev_level;
    end

    rpiq_fifo #(.PTR_W(PTR_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ev_valid),
        .push_ev  (in_ev),
        .pop      (reg_wr && (sel_ev0 || sel_ev1)),
        .push_ok  (push_ok),
        .dropped  (dropped),
        .nonempty (nonempty),
        .head     (head_ev),
        .wr_ptr   (fifo_wp),
        .rd_ptr   (fifo_rp)
    );

    rpiq_pend u_pend (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_ok       (push_ok),
        .nonempty      (nonempty),
        .pend_wr       (reg_wr && sel_pend),
        .pend_clr_intx (reg_wdata[B_INTX]),
        .mask_wr       (reg_wr && sel_mask),
        .mask_wdata    (reg_wdata),
        .pend_intx     (pend_intx),
        .pend_word     (pend_word),
        .mask_q        (mask_q),
        .irq           (irq_o)
    );

    rpiq_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (reg_wr && sel_ctl),
        .wr_bridge  (reg_wdata[B_BRIDGE]),
        .wr_ovf_clr (reg_wdata[B_OVF]),
        .dropped    (dropped),
        .bridge_en  (bridge_en_o),
        .ovf        (ovf_flag)
    );

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        if (sel_pend) reg_rdata = pend_word;
        if (sel_mask) reg_rdata = mask_q;
        if (sel_phy)  reg_rdata[B_LINK] = link_up;
        if (sel_ctl) begin
            reg_rdata[B_BRIDGE] = bridge_en_o;
            reg_rdata[B_NEMPTY] = nonempty;
            reg_rdata[B_OVF]    = ovf_flag;
        end
        if (sel_ev0 && nonempty) reg_rdata = ev_word(head_ev);
    end
endmodule

// File: rtl/rp_intx_queue_chk.sv
// Checker for rp_intx_queue, bound to every instance of the top.
// It observes the ports, the queue pointers and the pending and
// overflow state.
module rp_intx_queue_chk
    import rpiq_pkg::*;
#(
    parameter int unsigned PTR_W  = 4,
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [PTR_W-1:0]  wp,
    input logic [PTR_W-1:0]  rp,
    input logic              pend_intx,
    input logic              ovf,
    input logic              irq_o
);
    logic q_full, q_pop_wr, ovf_clr;
    assign q_full   = (wp + PTR_W'(1)) == rp;
    assign q_pop_wr = reg_wr && (reg_addr == ADDR_W'(OFF_EVW0) || reg_addr == ADDR_W'(OFF_EVW1));
    assign ovf_clr  = reg_wr && reg_addr == ADDR_W'(OFF_CTL) && reg_wdata[B_OVF];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && q_full) |=> (ovf && wp == $past(wp)));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    assert_pop_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop_wr && wp != rp) |=> rp == $past(rp) + PTR_W'(1));

    assert_pop_empty_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop_wr && wp == rp) |=> $stable(rp));

    assert_pending_while_queued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wp != rp) |-> pend_intx);

    assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_intx |-> !irq_o);

    assert_push_accepted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !q_full) |=> wp == $past(wp) + PTR_W'(1));
endmodule

bind rp_intx_queue rp_intx_queue_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wp        (fifo_wp),
    .rp        (fifo_rp),
    .pend_intx (pend_intx),
    .ovf       (ovf_flag),
    .irq_o     (irq_o)
);

// File: tb/rp_intx_queue_bench.sv
// Directed bench for rp_intx_queue: one task per scenario.
module rp_intx_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_lane = '0;
    logic        ev_level = 1'b0;
    logic        link_up = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic        bridge_en_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    rp_intx_queue u_rp_intx_queue (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_lane(ev_lane),
        .ev_level(ev_level), .link_up(link_up), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .bridge_en_o(bridge_en_o)
    );

    function automatic logic [31:0] exp_word(int lane, int lvl);
        return 32'h8000_0000 | (32'(lvl) << 29) | (32'(lane) << 27);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic push(int lane, int lvl);
        @(negedge clk);
        ev_valid = 1'b1; ev_lane = 2'(lane); ev_level = 1'(lvl);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic push_pop(int lane, int lvl);
        @(negedge clk);
        ev_valid = 1'b1; ev_lane = 2'(lane); ev_level = 1'(lvl);
        reg_wr = 1'b1; reg_addr = 12'h158; reg_wdata = '0;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R1 pending", 12'h138, 32'h0);
        rd_check("R1 mask", 12'h13C, 32'h0);
        rd_check("R1 ctl", 12'h148, 32'h0);
        rd_check("R1 word0 empty", 12'h158, 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 bridge", 32'(bridge_en_o), 32'h0);
    endtask

    task automatic t_link;
        @(negedge clk); link_up = 1'b1;
        rd_check("R8 link up", 12'h144, 32'h0000_0800);
        link_up = 1'b0;
        rd_check("R8 link down", 12'h144, 32'h0);
    endtask

    task automatic t_bridge;
        wr(12'h148, 32'h1);
        check("R9 bridge out", 32'(bridge_en_o), 32'h1);
        rd_check("R9 bridge read", 12'h148, 32'h1);
        wr(12'h148, 32'h0);
        check("R9 bridge off", 32'(bridge_en_o), 32'h0);
    endtask

    task automatic t_format;
        push(2, 1);
        rd_check("R2 word0", 12'h158, 32'hB000_0000);
        rd_check("R4 read keeps entry", 12'h158, 32'hB000_0000);
        rd_check("R2 word1 zero", 12'h15C, 32'h0);
        rd_check("R9 nonempty flag", 12'h148, 32'h0004_0000);
        wr(12'h15C, 32'h0);
        rd_check("R4 empty after pop", 12'h158, 32'h0);
        push(1, 0);
        push(3, 1);
        rd_check("R5 order first", 12'h158, 32'h8800_0000);
        wr(12'h158, 32'h0);
        rd_check("R5 order second", 12'h158, 32'hB800_0000);
        wr(12'h158, 32'h0);
        wr(12'h158, 32'h0);  // pop on empty
        rd_check("R5 empty pop flag", 12'h148, 32'h0);
        push(0, 1);
        rd_check("R5 after empty pop", 12'h158, 32'hA000_0000);
        wr(12'h158, 32'h0);
        rd_check("R9 flag clears", 12'h148, 32'h0);
    endtask

    task automatic t_pending;
        rd_check("R6 pending held", 12'h138, 32'h0001_0000);
        wr(12'h138, 32'h0001_0000);
        rd_check("R6 pending cleared", 12'h138, 32'h0);
        push(1, 1);
        rd_check("R6 set on push", 12'h138, 32'h0001_0000);
        wr(12'h138, 32'hFFFF_FFFF);
        rd_check("R6 re-forced", 12'h138, 32'h0001_0000);
        wr(12'h158, 32'h0);
        wr(12'h138, 32'h0001_0000);
        rd_check("R6 clear when empty", 12'h138, 32'h0);
    endtask

    task automatic t_mask;
        wr(12'h13C, 32'hFFFF_FFFF);
        rd_check("R7 mask read", 12'h13C, 32'hFFFF_FFFF);
        check("R7 no pending no irq", 32'(irq_o), 32'h0);
        push(0, 0);
        check("R7 irq on push", 32'(irq_o), 32'h1);
        wr(12'h13C, 32'h0);
        check("R7 masked", 32'(irq_o), 32'h0);
        wr(12'h13C, 32'h0001_0000);
        check("R7 unmasked", 32'(irq_o), 32'h1);
        wr(12'h158, 32'h0);
        wr(12'h138, 32'h0001_0000);
        check("R7 irq drops", 32'(irq_o), 32'h0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 15; i++) push(i % 4, i % 2);
        rd_check("R3 fifteen no ovf", 12'h148, 32'h0004_0000);
        push(3, 1);
        rd_check("R3 sixteenth drops", 12'h148, 32'h000C_0000);
        push_pop(2, 0);  // full: push dropped, pop taken
        rd_check("R11 head after full push_pop", 12'h158, exp_word(1, 1));
        for (int i = 1; i < 15; i++) begin
            rd_check("R3 drain order", 12'h158, exp_word(i % 4, i % 2));
            wr(12'h158, 32'h0);
        end
        rd_check("R3 empty after drain", 12'h158, 32'h0);
        rd_check("R3 ovf sticky", 12'h148, 32'h0008_0000);
        wr(12'h148, 32'h0008_0000);
        rd_check("R3 ovf cleared", 12'h148, 32'h0);
        wr(12'h138, 32'h0001_0000);
    endtask

    task automatic t_simul;
        push(1, 0);
        push_pop(2, 1);
        rd_check("R11 new entry kept", 12'h158, exp_word(2, 1));
        wr(12'h158, 32'h0);
        rd_check("R11 one entry only", 12'h148, 32'h0);
        wr(12'h138, 32'h0001_0000);
    endtask

    task automatic t_unmapped;
        wr(12'h13C, 32'h0000_1234);
        wr(12'h140, 32'h0);
        wr(12'h000, 32'hFFFF_FFFF);
        rd_check("R10 unmapped reads zero", 12'h000, 32'h0);
        rd_check("R10 unmapped 140", 12'h140, 32'h0);
        rd_check("R10 mask untouched", 12'h13C, 32'h0000_1234);
        rd_check("R10 ctl untouched", 12'h148, 32'h0);
        check("R10 bridge untouched", 32'(bridge_en_o), 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_link();
        t_bridge();
        t_format();
        t_pending();
        t_mask();
        t_overflow();
        t_simul();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule